// File: doc/BRIEF.md
# Configurable vertical sync pin generator

This block produces the vertical sync and field pins of a video timing path. Once per line it picks a line-start reference, which is either the end or the beginning of horizontal sync. It then counts pixel-enable ticks from that reference to find the mid-line point. At each of these two points it decides whether VS goes active or inactive. The decision uses two per-line flags: one marks the line on which VS begins and one marks the line on which VS ends.

Four position controls set where the VS edges fall. The odd and even fields each have a rising-edge control and a falling-edge control, and each control places its edge either at line start or at mid-line. The current field flag chooses which pair applies. VS and FIELD always drive dedicated pins. A third pin carries either FIELD or VS, chosen by a select bit. The control bits, the line flags, the field flag and the line length are all captured at the line-start reference. A control change made partway through a line therefore takes effect on the next line.

Top module: `vsync_pin_gen`

## Requirements
- R1: While rst_ni is low, vs_o, field_o and vs_field_o are 0. The captured controls return to 0: both VS edges at mid-line, hs-end as the reference, and FIELD on the combined pin.
- R2: The line-start reference is a tick with pix_en_i=1. When the captured ref_hs_begin is 0, that tick must also have hs_end_i=1. When it is 1, the tick must have hs_begin_i=1. A new ref_hs_begin_i value is captured at a reference and applies from the following reference onward.
- R3: The mid-line point is the (line_len_i/2)-th pix_en_i tick after the reference. line_len_i is captured at the reference and must be at least 2.
- R4: On an odd line (field_i=0) with vs_begin_line_i=1, vs_o goes to 1 after the reference edge when vs_beg_odd_i=1, and after the mid-line edge when vs_beg_odd_i=0.
- R5: On an even line (field_i=1) with vs_begin_line_i=1, vs_beg_even_i selects between the same two positions. vs_beg_odd_i has no effect on such a line.
- R6: On an odd line with vs_end_line_i=1, vs_o goes to 0 after the reference edge when vs_end_odd_i=1, and after the mid-line edge when it is 0.
- R7: On an even line with vs_end_line_i=1, vs_end_even_i selects the clear position. vs_end_odd_i has no effect on such a line.
- R8: When a set and a clear fall at the same point, the clear wins. At any point that has neither, vs_o holds its value.
- R9: field_o takes the value of field_i captured at the reference, one cycle after the reference tick.
- R10: vs_field_o carries field_o when the captured pin_sel_vs is 0 and vs_o when it is 1. The select is captured at the reference.
- R11: If a position control or the pin select changes after the reference, the current line ignores the change. The change applies from the next reference.
- R12: The mid-line count advances only on cycles with pix_en_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-clock enable |
| hs_begin_i | input | 1 | Pulse at the start of horizontal sync |
| hs_end_i | input | 1 | Pulse at the end of horizontal sync |
| field_i | input | 1 | Field flag: 0 odd, 1 even |
| vs_begin_line_i | input | 1 | Set on the line where VS goes active |
| vs_end_line_i | input | 1 | Set on the line where VS goes inactive |
| line_len_i | input | LEN_W | Line length in pixel-enable ticks |
| vs_beg_odd_i | input | 1 | Odd-field VS rise: 1 at line start, 0 at mid-line |
| vs_beg_even_i | input | 1 | Even-field VS rise: 1 at line start, 0 at mid-line |
| vs_end_odd_i | input | 1 | Odd-field VS fall: 1 at line start, 0 at mid-line |
| vs_end_even_i | input | 1 | Even-field VS fall: 1 at line start, 0 at mid-line |
| ref_hs_begin_i | input | 1 | Line-start reference: 0 hs end, 1 hs begin |
| pin_sel_vs_i | input | 1 | Combined pin: 0 FIELD, 1 VS |
| vs_o | output | 1 | Vertical sync, active high |
| field_o | output | 1 | Field pin |
| vs_field_o | output | 1 | Combined VS/FIELD pin |

## Verification
The bench runs lines in which the set and the clear fall on the same line at the same point. A design that lets the set win would leave VS stuck high there. Other lines carry the wrong field's control bits set to the opposite value. Swapping the odd and even controls would then move an edge by half a line. The bench also changes the position control and the pin select in mid-line, and checks that VS still moves at the captured position. It switches the reference to the hs-begin edge and checks mid-line three ticks earlier. If the inactive hs-end pulse still restarted the counter, the mid-line point would fall late. Gated pixel enables and a shortened line catch a counter that runs on every clock or ignores the line length.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  typedef struct packed {
    logic beg_odd;
    logic beg_even;
    logic end_odd;
    logic end_even;
    logic ref_hsb;
    logic out_vs;
  } vsg_ctrl_t;

  typedef struct packed {
    logic field;
    logic beg_line;
    logic end_line;
  } vsg_line_t;

  localparam vsg_ctrl_t CTRL_RST = '0;
  localparam vsg_line_t LINE_RST = '0;

  // 1 = edge at line start, 0 = edge at mid-line
  function automatic logic beg_at_start(vsg_ctrl_t c, logic even);
    return even ? c.beg_even : c.beg_odd;
  endfunction

  function automatic logic end_at_start(vsg_ctrl_t c, logic even);
    return even ? c.end_even : c.end_odd;
  endfunction

endpackage

// File: rtl/vsg_line_timer.sv
module vsg_line_timer #(
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned DEF_LEN = 1716
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic             hs_begin_i,
  input  logic             hs_end_i,
  input  logic             ref_hsb_i,
  input  logic [LEN_W-1:0] line_len_i,
  output logic             ref_o,
  output logic             mid_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_RST = LEN_W'(DEF_LEN);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] mid_cnt;

  assign ref_o   = pix_en_i & (ref_hsb_i ? hs_begin_i : hs_end_i);
  assign mid_cnt = (len_q >> 1) - LEN_W'(1);
  assign mid_o   = pix_en_i & ~ref_o & (cnt_q == mid_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= LEN_RST;
      cnt_q <= '0;
    end else if (ref_o) begin
      len_q <= line_len_i;
      cnt_q <= '0;
    end else if (pix_en_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  p_cnt_restart_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> (cnt_q == '0));

  p_cnt_gated_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_en_i) |=> $stable(cnt_q));

endmodule

// File: rtl/vsg_ctrl_latch.sv
module vsg_ctrl_latch
  import vsg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_i,
  input  vsg_ctrl_t ctrl_i,
  input  vsg_line_t line_i,
  output vsg_ctrl_t ctrl_q_o,
  output vsg_line_t line_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q_o <= CTRL_RST;
      line_q_o <= LINE_RST;
    end else if (ref_i) begin
      ctrl_q_o <= ctrl_i;
      line_q_o <= line_i;
    end
  end

  p_ctrl_hold_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_i) |=> ($stable(ctrl_q_o) && $stable(line_q_o)));

endmodule

// File: rtl/vsg_vs_core.sv
module vsg_vs_core
  import vsg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_i,
  input  logic      mid_i,
  input  vsg_ctrl_t ctrl_i,
  input  vsg_line_t line_i,
  input  vsg_ctrl_t ctrl_q_i,
  input  vsg_line_t line_q_i,
  output logic      vs_o
);
  logic set_start, clr_start, set_mid, clr_mid;
  logic vs_q, vs_d;

  // start-of-line events use this line's values as they are captured
  assign set_start = ref_i & line_i.beg_line & beg_at_start(ctrl_i, line_i.field);
  assign clr_start = ref_i & line_i.end_line & end_at_start(ctrl_i, line_i.field);
  // mid-line events use the values captured at the reference
  assign set_mid   = mid_i & line_q_i.beg_line & ~beg_at_start(ctrl_q_i, line_q_i.field);
  assign clr_mid   = mid_i & line_q_i.end_line & ~end_at_start(ctrl_q_i, line_q_i.field);

  always_comb begin
    vs_d = vs_q;
    if (set_start | set_mid) vs_d = 1'b1;
    if (clr_start | clr_mid) vs_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_q <= 1'b0;
    else         vs_q <= vs_d;
  end

  assign vs_o = vs_q;

  p_vs_on_event_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_q != $past(vs_q)) |-> $past(ref_i || mid_i));

  p_clear_wins_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_i && line_i.beg_line && line_i.end_line
     && beg_at_start(ctrl_i, line_i.field) && end_at_start(ctrl_i, line_i.field))
    |=> !vs_q);

endmodule

// File: rtl/vsync_pin_gen.sv
module vsync_pin_gen
  import vsg_pkg::*;
#(
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned DEF_LEN = 1716
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic             hs_begin_i,
  input  logic             hs_end_i,
  input  logic             field_i,
  input  logic             vs_begin_line_i,
  input  logic             vs_end_line_i,
  input  logic [LEN_W-1:0] line_len_i,
  input  logic             vs_beg_odd_i,
  input  logic             vs_beg_even_i,
  input  logic             vs_end_odd_i,
  input  logic             vs_end_even_i,
  input  logic             ref_hs_begin_i,
  input  logic             pin_sel_vs_i,
  output logic             vs_o,
  output logic             field_o,
  output logic             vs_field_o
);
  vsg_ctrl_t ctrl_in, ctrl_q;
  vsg_line_t line_in, line_q;
  logic      ref_evt, mid_evt;

  assign ctrl_in = '{beg_odd:  vs_beg_odd_i,  beg_even: vs_beg_even_i,
                     end_odd:  vs_end_odd_i,  end_even: vs_end_even_i,
                     ref_hsb:  ref_hs_begin_i, out_vs:  pin_sel_vs_i};
  assign line_in = '{field: field_i, beg_line: vs_begin_line_i,
                     end_line: vs_end_line_i};

  vsg_line_timer #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_en_i   (pix_en_i),
    .hs_begin_i (hs_begin_i),
    .hs_end_i   (hs_end_i),
    .ref_hsb_i  (ctrl_q.ref_hsb),
    .line_len_i (line_len_i),
    .ref_o      (ref_evt),
    .mid_o      (mid_evt)
  );

  vsg_ctrl_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_i    (ref_evt),
    .ctrl_i   (ctrl_in),
    .line_i   (line_in),
    .ctrl_q_o (ctrl_q),
    .line_q_o (line_q)
  );

  vsg_vs_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_i    (ref_evt),
    .mid_i    (mid_evt),
    .ctrl_i   (ctrl_in),
    .line_i   (line_in),
    .ctrl_q_i (ctrl_q),
    .line_q_i (line_q),
    .vs_o     (vs_o)
  );

  assign field_o    = line_q.field;
  assign vs_field_o = ctrl_q.out_vs ? vs_o : line_q.field;

  p_field_at_ref_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o != $past(field_o)) |-> $past(ref_evt));

  p_pin_choice_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_field_o == vs_o) || (vs_field_o == field_o));

  p_reset_low_r1 : assert property (@(posedge clk_i)
    (!rst_ni) |-> (!vs_o && !field_o && !vs_field_o));

endmodule

// File: tb/vsync_pin_gen_tb.sv
module vsync_pin_gen_tb;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pix_en_i = 0, hs_begin_i = 0, hs_end_i = 0, field_i = 0;
  logic vs_begin_line_i = 0, vs_end_line_i = 0;
  logic [LEN_W-1:0] line_len_i = LEN_W'(16);
  logic vs_beg_odd_i = 0, vs_beg_even_i = 0, vs_end_odd_i = 0, vs_end_even_i = 0;
  logic ref_hs_begin_i = 0, pin_sel_vs_i = 0;
  logic vs_o, field_o, vs_field_o;

  int n_chk = 0, n_err = 0;
  logic cur_ref = 1'b0;

  always #2 clk = ~clk;

  vsync_pin_gen #(.LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en_i),
    .hs_begin_i(hs_begin_i), .hs_end_i(hs_end_i), .field_i(field_i),
    .vs_begin_line_i(vs_begin_line_i), .vs_end_line_i(vs_end_line_i),
    .line_len_i(line_len_i),
    .vs_beg_odd_i(vs_beg_odd_i), .vs_beg_even_i(vs_beg_even_i),
    .vs_end_odd_i(vs_end_odd_i), .vs_end_even_i(vs_end_even_i),
    .ref_hs_begin_i(ref_hs_begin_i), .pin_sel_vs_i(pin_sel_vs_i),
    .vs_o(vs_o), .field_o(field_o), .vs_field_o(vs_field_o)
  );

  // {beg_odd, beg_even, end_odd, end_even, pin_sel, field, bline, eline, exp_start, exp_mid}
  localparam logic [9:0] VEC [13] = '{
    10'b0000_0_0_1_0_0_1,  // R4 default: rise at mid-line
    10'b0000_0_0_0_0_1_1,  // R8 no flags: hold
    10'b0000_0_0_0_1_1_0,  // R6 fall at mid-line
    10'b1000_0_0_1_0_1_1,  // R4 rise at start
    10'b0010_0_0_0_1_0_0,  // R6 fall at start
    10'b1000_0_1_1_0_0_1,  // R5 even uses beg_even=0, beg_odd ignored
    10'b0001_0_1_0_1_0_0,  // R7 even fall at start
    10'b0100_1_1_1_0_1_1,  // R5 even rise at start, R10 VS on combined pin
    10'b0010_1_1_0_1_1_0,  // R7 even fall at mid, end_odd ignored
    10'b1000_0_0_1_1_1_0,  // R8 set at start, clear at mid
    10'b1010_0_0_1_1_0_0,  // R8 set and clear at start: clear wins
    10'b0010_0_0_1_1_0_1,  // R6 clear at start, R4 set at mid
    10'b0000_0_1_1_1_1_0   // R8 set and clear at mid: clear wins
  };

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // one line of 16 ticks; each tick spans div cycles
  task automatic run_line(input int div, input logic xs, input logic xm,
                          input bit flip, input string rq);
    int  r    = cur_ref ? 0 : 3;
    int  h    = int'(line_len_i) / 2;
    logic fld = field_i;
    logic mux = pin_sel_vs_i;
    for (int c = 0; c < 16 * div; c++) begin
      @(negedge clk);
      pix_en_i   = (c % div == 0);
      hs_begin_i = (c == 0);
      hs_end_i   = (c == 3 * div);
      if (flip && c == r * div + 1) begin
        vs_beg_odd_i = 1'b1;
        pin_sel_vs_i = 1'b1;
      end
      @(posedge clk);
      #1;
      if (c == r * div) begin
        chk(vs_o, xs, {rq, " vs at line start"});
        chk(field_o, fld, "R9 field pin");
        chk(vs_field_o, mux ? xs : fld, "R10 combined pin at start");
      end
      if (c == (r + h) * div - 1) chk(vs_o, xs, {rq, " vs before mid-line"});
      if (c == (r + h) * div) begin
        chk(vs_o, xm, {rq, " vs at mid-line"});
        chk(vs_field_o, mux ? xm : fld, "R10 R11 combined pin at mid");
      end
    end
    @(negedge clk);
    pix_en_i = 0; hs_begin_i = 0; hs_end_i = 0;
    cur_ref = ref_hs_begin_i;
  endtask

  task automatic set_line(input logic [9:0] v);
    {vs_beg_odd_i, vs_beg_even_i, vs_end_odd_i, vs_end_even_i,
     pin_sel_vs_i, field_i, vs_begin_line_i, vs_end_line_i} = v[9:2];
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired (R1-related run hang)");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(vs_o, 1'b0, "R1 reset vs");
    chk(field_o, 1'b0, "R1 reset field");
    chk(vs_field_o, 1'b0, "R1 reset combined");
    @(negedge clk) rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      set_line(VEC[i]);
      run_line(1, VEC[i][1], VEC[i][0], 1'b0, $sformatf("R4-R8 row %0d", i));
    end

    // R12: pixel enable every other cycle
    set_line(10'b0000_0_0_1_0_0_0);
    run_line(2, 1'b0, 1'b1, 1'b0, "R12 gated ticks");

    // R3: shorter line moves mid-line point
    line_len_i = LEN_W'(10);
    set_line(10'b0000_0_0_0_1_0_0);
    run_line(1, 1'b1, 1'b0, 1'b0, "R3 line length 10");
    line_len_i = LEN_W'(16);

    // R11: control and pin select flipped after the reference
    set_line(10'b0000_0_0_1_0_0_0);
    run_line(1, 1'b0, 1'b1, 1'b1, "R11 mid-line control change");
    vs_begin_line_i = 0;
    run_line(1, 1'b1, 1'b1, 1'b0, "R10 R11 select applied next line");

    // R2: switch reference to hs begin
    set_line(10'b0001_0_1_0_1_0_0);
    ref_hs_begin_i = 1'b1;
    run_line(1, 1'b0, 1'b0, 1'b0, "R2 R7 transition line");
    set_line(10'b0000_0_1_1_0_0_1);
    run_line(1, 1'b0, 1'b1, 1'b0, "R2 hs-begin reference");

    // R1: reset mid-run restores outputs and default controls
    @(negedge clk) rst_ni = 1'b0;
    #1;
    chk(vs_o, 1'b0, "R1 reset vs after run");
    chk(field_o, 1'b0, "R1 reset field after run");
    chk(vs_field_o, 1'b0, "R1 reset combined after run");
    @(negedge clk) rst_ni = 1'b1;
    cur_ref = 1'b0;
    set_line(10'b1000_0_0_1_0_0_0);
    run_line(1, 1'b1, 1'b1, 1'b0, "R1 R2 default hs-end reference");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule